// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block turns a single logical block write into the physical disk operations needed to keep parity correct in a five-column array. Parity rotates across the columns from stripe to stripe. A request carries a logical block address and the new block contents, and it is taken in over a valid/ready handshake. The engine works out the stripe, the column that holds the data block, and the column that holds parity for that stripe. The physical block offset on every disk equals the stripe number.

The engine then issues four commands, one at a time, on a per-disk command port. Each command stays asserted until the disk side acknowledges it. The first two commands read the old data block and the old parity block. The last two write the new data block and the new parity block. New parity is computed as old parity XOR old data XOR new data, so the other data disks in the stripe are never read. A one-cycle done pulse marks the end of the update. Only one update is in flight at a time.

Top module: `parity_update_engine`

## Requirements
- R1: `req_ready` is high only when the engine is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the update completes.
- R2: The stripe is the address divided by 4. The parity column is 4 minus (stripe mod 5), so stripe 0 puts parity in column 4 and stripe 4 puts it in column 0. Every command's `dsk_blk` equals the stripe.
- R3: With k the address mod 4, the data column is k when k is below the parity column, and k+1 otherwise. The data column never equals the parity column.
- R4: Each update issues exactly four commands in this order: read data column (`dsk_write`=0), read parity column (`dsk_write`=0), write data column (`dsk_write`=1), write parity column (`dsk_write`=1). No write is issued before both reads are acknowledged.
- R5: The data write carries the new data. The parity write carries old parity XOR old data XOR new data, where the old values are the `dsk_rdata` returned with the two read acknowledges. Afterwards, all five columns of the stripe XOR to zero.
- R6: While `dsk_valid` is high and `dsk_ack` is low, the command (`dsk_col`, `dsk_write`, `dsk_blk`, `dsk_wdata`) holds steady. The next command appears in the cycle after the acknowledge.
- R7: `done` is high for exactly one cycle: the cycle after the parity write is acknowledged. In that cycle `dsk_valid` is low and `req_ready` is high.
- R8: Reset, including reset in the middle of an update, returns the engine to idle with `dsk_valid` low, `done` low and `req_ready` high.
- R9: While the engine is busy, `req_valid`, `req_lba` and `req_data` have no effect on the commands of the update in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_lba | input | LBA_W | Logical block address |
| req_data | input | DATA_W | New block contents |
| dsk_valid | output | 1 | Disk command present, held until acknowledged |
| dsk_write | output | 1 | 1 = write, 0 = read |
| dsk_col | output | $clog2(NCOL) | Target disk column |
| dsk_blk | output | LBA_W | Block offset on the disk (the stripe) |
| dsk_wdata | output | DATA_W | Write data |
| dsk_ack | input | 1 | Disk acknowledges the current command |
| dsk_rdata | input | DATA_W | Read data, valid with `dsk_ack` on reads |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives while an update is in progress: it must not leak into the update's commands. The bench keeps `req_valid` high with a different address and data through a whole update. It checks every command against the first request, then drops the request in the done cycle. The second is a reset that lands mid-sequence. The bench pulls reset after the first read is issued, checks that the port goes quiet, and then runs a full update on the same stripe. The disk model lets acknowledges be delayed by several cycles, which exercises the hold rule. It keeps parity consistent across the whole array, so a wrong XOR shows up both in the write data and in the stripe check afterwards.

// File: rtl/pue_pkg.sv
package pue_pkg;

    // Steps of one small write, in issue order
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_OLD = 3'd1,
        ST_RD_PAR = 3'd2,
        ST_WR_NEW = 3'd3,
        ST_WR_PAR = 3'd4
    } step_e;

endpackage

// File: rtl/pue_map.sv
module pue_map #(
    parameter int NCOL  = 5,
    parameter int LBA_W = 16,
    localparam int COL_W = $clog2(NCOL),
    localparam int DPS   = NCOL - 1
) (
    input  logic [LBA_W-1:0] lba,
    output logic [LBA_W-1:0] stripe,
    output logic [COL_W-1:0] dcol,
    output logic [COL_W-1:0] pcol
);

    logic [LBA_W-1:0] stripe_w, k_w, smod_w, pcol_w, dcol_w;

    always_comb begin
        stripe_w = lba / LBA_W'(DPS);
        k_w      = lba % LBA_W'(DPS);
        smod_w   = stripe_w % LBA_W'(NCOL);
        pcol_w   = LBA_W'(NCOL - 1) - smod_w;
        dcol_w   = (k_w < pcol_w) ? k_w : k_w + LBA_W'(1);
    end

    assign stripe = stripe_w;
    assign dcol   = dcol_w[COL_W-1:0];
    assign pcol   = pcol_w[COL_W-1:0];

    // R3
    always_comb begin
        col_range_chk: assert (dcol_w < LBA_W'(NCOL) && pcol_w < LBA_W'(NCOL) && dcol_w != pcol_w)
            else $error("column map out of range or data on parity column");
    end

endmodule

// File: rtl/pue_seq.sv
module pue_seq
    import pue_pkg::*;
#(
    parameter int NCOL   = 5,
    parameter int LBA_W  = 16,
    parameter int DATA_W = 32,
    localparam int COL_W = $clog2(NCOL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LBA_W-1:0]  map_stripe,
    input  logic [COL_W-1:0]  map_dcol,
    input  logic [COL_W-1:0]  map_pcol,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [COL_W-1:0]  cmd_col,
    output logic [LBA_W-1:0]  cmd_blk,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] cmd_rdata,
    output logic              done
);

    typedef struct packed {
        step_e             st;
        logic [COL_W-1:0]  dcol;
        logic [COL_W-1:0]  pcol;
        logic [LBA_W-1:0]  blk;
        logic [DATA_W-1:0] nd;
        logic [DATA_W-1:0] od;
        logic [DATA_W-1:0] np;
        logic              done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.st   = ST_RD_OLD;
                    ctx_d.dcol = map_dcol;
                    ctx_d.pcol = map_pcol;
                    ctx_d.blk  = map_stripe;
                    ctx_d.nd   = req_data;
                end
            end
            ST_RD_OLD: begin
                if (cmd_ack) begin
                    ctx_d.od = cmd_rdata;
                    ctx_d.st = ST_RD_PAR;
                end
            end
            ST_RD_PAR: begin
                if (cmd_ack) begin
                    ctx_d.np = cmd_rdata ^ ctx_q.od ^ ctx_q.nd;
                    ctx_d.st = ST_WR_NEW;
                end
            end
            ST_WR_NEW: begin
                if (cmd_ack) ctx_d.st = ST_WR_PAR;
            end
            ST_WR_PAR: begin
                if (cmd_ack) begin
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready = (ctx_q.st == ST_IDLE);
    assign cmd_valid = (ctx_q.st != ST_IDLE);
    assign cmd_write = (ctx_q.st == ST_WR_NEW) || (ctx_q.st == ST_WR_PAR);
    assign cmd_col   = ((ctx_q.st == ST_RD_PAR) || (ctx_q.st == ST_WR_PAR)) ? ctx_q.pcol : ctx_q.dcol;
    assign cmd_blk   = ctx_q.blk;
    assign cmd_wdata = (ctx_q.st == ST_WR_PAR) ? ctx_q.np : ctx_q.nd;
    assign done      = ctx_q.done;

    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_col) && $stable(cmd_write)
                                     && $stable(cmd_blk) && $stable(cmd_wdata)));

    // R4
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_write) |-> $past(cmd_valid && !cmd_write && cmd_ack));

    // R4
    first_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> !cmd_write);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd_valid && cmd_write && cmd_ack) && req_ready && !cmd_valid));

endmodule

// File: rtl/parity_update_engine.sv
module parity_update_engine #(
    parameter int NCOL   = 5,
    parameter int LBA_W  = 16,
    parameter int DATA_W = 32,
    localparam int COL_W = $clog2(NCOL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LBA_W-1:0]  req_lba,
    input  logic [DATA_W-1:0] req_data,
    output logic              dsk_valid,
    output logic              dsk_write,
    output logic [COL_W-1:0]  dsk_col,
    output logic [LBA_W-1:0]  dsk_blk,
    output logic [DATA_W-1:0] dsk_wdata,
    input  logic              dsk_ack,
    input  logic [DATA_W-1:0] dsk_rdata,
    output logic              done
);

    logic [LBA_W-1:0] map_stripe;
    logic [COL_W-1:0] map_dcol;
    logic [COL_W-1:0] map_pcol;

    pue_map #(
        .NCOL  (NCOL),
        .LBA_W (LBA_W)
    ) i_map (
        .lba    (req_lba),
        .stripe (map_stripe),
        .dcol   (map_dcol),
        .pcol   (map_pcol)
    );

    pue_seq #(
        .NCOL   (NCOL),
        .LBA_W  (LBA_W),
        .DATA_W (DATA_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_data   (req_data),
        .map_stripe (map_stripe),
        .map_dcol   (map_dcol),
        .map_pcol   (map_pcol),
        .cmd_valid  (dsk_valid),
        .cmd_write  (dsk_write),
        .cmd_col    (dsk_col),
        .cmd_blk    (dsk_blk),
        .cmd_wdata  (dsk_wdata),
        .cmd_ack    (dsk_ack),
        .cmd_rdata  (dsk_rdata),
        .done       (done)
    );

endmodule

// File: tb/test_parity_update_engine.sv
module test_parity_update_engine;

    localparam int NCOL   = 5;
    localparam int LBA_W  = 16;
    localparam int DATA_W = 32;
    localparam int NBLK   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LBA_W-1:0]  req_lba = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              dsk_valid;
    logic              dsk_write;
    logic [2:0]        dsk_col;
    logic [LBA_W-1:0]  dsk_blk;
    logic [DATA_W-1:0] dsk_wdata;
    logic              dsk_ack = 1'b0;
    logic [DATA_W-1:0] dsk_rdata = '0;
    logic              done;

    int total = 0;
    int bad   = 0;

    logic [DATA_W-1:0] mem [NCOL][NBLK];

    parity_update_engine #(
        .NCOL(NCOL), .LBA_W(LBA_W), .DATA_W(DATA_W)
    ) i_parity_update_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_lba(req_lba), .req_data(req_data),
        .dsk_valid(dsk_valid), .dsk_write(dsk_write),
        .dsk_col(dsk_col), .dsk_blk(dsk_blk), .dsk_wdata(dsk_wdata),
        .dsk_ack(dsk_ack), .dsk_rdata(dsk_rdata), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary_and_end();
    end

    task automatic init_mem();
        for (int s = 0; s < NBLK; s++) begin
            logic [DATA_W-1:0] acc;
            int p;
            acc = '0;
            p = NCOL - 1 - (s % NCOL);
            for (int c = 0; c < NCOL; c++) begin
                if (c != p) begin
                    mem[c][s] = 32'h9E37_79B9 * (s * 8 + c + 1);
                    acc ^= mem[c][s];
                end
            end
            mem[p][s] = acc;
        end
    endtask

    // One full update; delay = extra cycles before each ack; noise keeps a second request pending (R9)
    task automatic run_write(input int lba, input logic [DATA_W-1:0] nd, input int delay, input bit noise);
        int s, k, pc, dc, w;
        logic [DATA_W-1:0] od, op, xr;
        s  = lba / 4;
        k  = lba % 4;
        pc = 4 - (s % 5);
        dc = (k < pc) ? k : k + 1;
        od = mem[dc][s];
        op = mem[pc][s];
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 1);
        req_valid = 1'b1;
        req_lba   = LBA_W'(lba);
        req_data  = nd;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 0);
        if (noise) begin
            req_lba  = LBA_W'(lba + 5);
            req_data = ~nd;
        end else begin
            req_valid = 1'b0;
        end
        for (int step = 0; step < 4; step++) begin
            bit ew;
            int ec;
            logic [2:0] col0;
            logic [DATA_W-1:0] wd0;
            ew = (step >= 2);
            ec = (step % 2 == 1) ? pc : dc;
            w = 0;
            while (!dsk_valid && w < 20) begin
                @(negedge clk);
                w++;
            end
            chk(dsk_valid == 1'b1, "R4", "command issued", 64'(dsk_valid), 1);
            chk(dsk_write == ew, "R4", "command direction", 64'(dsk_write), 64'(ew));
            chk(int'(dsk_col) == ec, (step % 2 == 1) ? "R2" : "R3", "command column", 64'(dsk_col), 64'(ec));
            chk(int'(dsk_blk) == s, "R2", "block offset", 64'(dsk_blk), 64'(s));
            if (step == 2) chk(dsk_wdata == nd, "R5", "new data write", 64'(dsk_wdata), 64'(nd));
            if (step == 3) chk(dsk_wdata == (op ^ od ^ nd), "R5", "new parity write",
                               64'(dsk_wdata), 64'(op ^ od ^ nd));
            col0 = dsk_col;
            wd0  = dsk_wdata;
            for (int d = 0; d < delay; d++) begin
                @(negedge clk);
                chk(dsk_valid && dsk_col == col0 && dsk_write == ew && dsk_wdata == wd0 && !done,
                    "R6", "command held until ack", 64'(dsk_col), 64'(col0));
            end
            dsk_ack = 1'b1;
            if (ew) begin
                mem[dsk_col][dsk_blk[5:0]] = dsk_wdata;
                dsk_rdata = '0;
            end else begin
                dsk_rdata = mem[dsk_col][dsk_blk[5:0]];
            end
            @(negedge clk);
            dsk_ack = 1'b0;
            if (step < 3) chk(done == 1'b0, "R7", "no done mid-sequence", 64'(done), 0);
        end
        chk(done == 1'b1, "R7", "done after last ack", 64'(done), 1);
        chk(dsk_valid == 1'b0, "R4", "no fifth command", 64'(dsk_valid), 0);
        chk(req_ready == 1'b1, "R7", "ready with done", 64'(req_ready), 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle only", 64'(done), 0);
        chk(dsk_valid == 1'b0, "R9", "pending request not taken", 64'(dsk_valid), 0);
        xr = '0;
        for (int c = 0; c < NCOL; c++) xr ^= mem[c][s];
        chk(xr == '0, "R5", "stripe parity consistent", 64'(xr), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(dsk_valid == 1'b0 && done == 1'b0, "R8", "quiet in reset", 64'({dsk_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready after reset", 64'(req_ready), 1);
        chk(dsk_valid == 1'b0, "R8", "no command after reset", 64'(dsk_valid), 0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        req_valid = 1'b1;
        req_lba   = LBA_W'(9);
        req_data  = 32'hDEAD_0009;
        @(negedge clk);
        req_valid = 1'b0;
        chk(dsk_valid == 1'b1, "R8", "first read before reset", 64'(dsk_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dsk_valid == 1'b0, "R8", "command dropped by reset", 64'(dsk_valid), 0);
        chk(req_ready == 1'b1 && done == 1'b0, "R8", "idle in reset", 64'({req_ready, done}), 64'(2));
        rst_n = 1'b1;
        @(negedge clk);
        run_write(9, 32'h0BAD_F00D, 0, 1'b0);
    endtask

    initial begin
        init_mem();
        repeat (2) @(negedge clk);
        t_reset();
        // stripe 0: parity col 4, data col 0 (R2 R3)
        run_write(0, 32'h1111_2222, 0, 1'b0);
        // stripe 1: parity col 3, blocks 4..7 land in cols 0,1,2,4 (R3)
        for (int l = 4; l < 8; l++) run_write(l, 32'hA5A5_0000 + l, 0, 1'b0);
        // stripe 4: parity col 0, every data block shifted right
        run_write(16, 32'h4444_0010, 0, 1'b0);
        run_write(19, 32'h4444_0013, 1, 1'b0);
        // stripe 5 wraps back to parity col 4
        run_write(23, 32'h5555_0017, 0, 1'b0);
        // slow disk acks (R6)
        run_write(42, 32'hC0DE_CAFE, 3, 1'b0);
        // pending request during busy (R9)
        run_write(13, 32'h7777_000D, 2, 1'b1);
        // same block twice: second update reads first update's data
        run_write(13, 32'h8888_000D, 0, 1'b0);
        t_mid_reset();
        summary_and_end();
    end

endmodule